// File: doc/BRIEF.md
# Job-Slot Interrupt and Activity-State Controller

This block collects per-slot completion and failure pulses from sixteen job slots into a single 32-bit interrupt word. It also keeps a packed record of which slots hold a running job and which hold a queued follow-on job. Software reaches the block through a simple 32-bit register port. Addresses below the slot base select the local interrupt and state registers. Addresses at or above the slot base are decoded into a slot number and a byte offset and passed straight to the slot register windows. Read data for those addresses comes back unchanged.

Done pulses land in the low half of the raw interrupt word and fail pulses in the high half. A mask gates the raw word into a masked status word, and any set masked bit drives a level interrupt line. Acknowledging interrupts through the clear register also refreshes the activity state of each slot named by the clear value. That refresh samples the active and queued flags that the slots present on that cycle.

Top module: `jobslot_irq_ctrl`

## Requirements
- R1: After reset the raw interrupt word, the mask and the activity state word are all zero, `irq` is low and `rd_valid` is low.
- R2: A done pulse on slot n sets raw bit n and a fail pulse on slot n sets raw bit 16+n. Set bits stay set until cleared.
- R3: Masked status equals raw AND mask, and `irq` is high exactly when masked status is nonzero.
- R4: A write to the clear register clears every raw bit written as 1. The clear register reads as zero. If a pulse sets a bit in the same cycle that a clear removes it, the bit ends set.
- R5: A clear write with value W refreshes the affected slots, which are given by W[15:0] OR W[31:16]. For each affected slot n, state bit n takes `slot_active[n]` and state bit 16+n takes `slot_next[n]`, both sampled in the cycle of the write.
- R6: State bits of slots outside the affected set keep their value, and the state word changes only on a clear write.
- R7: A request with address at or above 0x800 raises `win_req` in the same cycle. It sets `win_slot` = (addr−0x800)>>7 and `win_off` = addr[6:0], and passes `reg_wr` and `reg_wdata` through. Such a request leaves the local registers untouched. Addresses below 0x800 never raise `win_req`.
- R8: `rd_valid` is high in the cycle after a read request. `rd_data` then holds the local register value from the request cycle. For a forwarded address it holds the `win_rdata` seen in the request cycle.
- R9: The local offsets are 0x000 raw (read-only), 0x004 clear, 0x008 mask (read/write), 0x00C masked status (read-only) and 0x010 state (read-only). Writes to read-only offsets are ignored, and any other local offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| slot_done | input | 16 | Per-slot completion pulses |
| slot_fail | input | 16 | Per-slot failure pulses |
| slot_active | input | 16 | Per-slot running-job flags |
| slot_next | input | 16 | Per-slot queued-job flags |
| irq | output | 1 | Level interrupt |
| win_req | output | 1 | Forwarded window access |
| win_wr | output | 1 | Forwarded write flag |
| win_slot | output | 4 | Target slot number |
| win_off | output | 7 | Byte offset inside the slot window |
| win_wdata | output | 32 | Forwarded write data |
| win_rdata | input | 32 | Read data from the addressed slot window |

## Verification
Assertions check on every cycle that pulses always leave their raw bits set, even against a simultaneous clear. They also check that cleared bits without a pulse are gone on the next cycle and that the raw word holds when nothing touches it. For state, they check that the state word is frozen outside clear writes and that refreshed bits match the sampled slot flags. Whether unaffected slots keep their state bits, the exact window slot/offset decode at the 0x7FC/0x800/0xFFF edges, the read-back of every local offset and the pass-through of window read data are shown only by the bench. The bench compares each read and each `irq` value against its own model.

// File: rtl/jsc_pkg.sv
package jsc_pkg;
    localparam int NSLOT  = 16;
    localparam int DW     = 32;
    localparam int SLOT_W = $clog2(NSLOT);

    // local register byte offsets
    localparam logic [11:0] OFS_RAW   = 12'h000;
    localparam logic [11:0] OFS_CLR   = 12'h004;
    localparam logic [11:0] OFS_MASK  = 12'h008;
    localparam logic [11:0] OFS_STAT  = 12'h00C;
    localparam logic [11:0] OFS_STATE = 12'h010;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_RAW, SEL_CLR, SEL_MASK, SEL_STAT, SEL_STATE
    } loc_sel_e;

    typedef struct packed {
        logic [DW-1:0] raw;
        logic [DW-1:0] mask;
    } irq_regs_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } rd_regs_t;
endpackage

// File: rtl/jsc_decode.sv
module jsc_decode
    import jsc_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SLOT_BASE = 12'h800,
    parameter int          WIN_BYTES = 128
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic                        is_win,
    output loc_sel_e                    sel,
    output logic [SLOT_W-1:0]           slot,
    output logic [$clog2(WIN_BYTES)-1:0] off
);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        is_win = (addr >= ADDR_W'(SLOT_BASE));
        rel    = addr - ADDR_W'(SLOT_BASE);
        slot   = rel[OFF_W +: SLOT_W];
        off    = rel[OFF_W-1:0];
        sel    = SEL_NONE;
        if (!is_win) begin
            case (addr)
                ADDR_W'(OFS_RAW):   sel = SEL_RAW;
                ADDR_W'(OFS_CLR):   sel = SEL_CLR;
                ADDR_W'(OFS_MASK):  sel = SEL_MASK;
                ADDR_W'(OFS_STAT):  sel = SEL_STAT;
                ADDR_W'(OFS_STATE): sel = SEL_STATE;
                default:            sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/jsc_irq_regs.sv
module jsc_irq_regs
    import jsc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] raw_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] stat_o,
    output logic          irq_o
);
    irq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_we) r_d.raw = r_q.raw & ~wdata;
        r_d.raw = r_d.raw | ev;     // set wins over clear
        if (mask_we) r_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign raw_o  = r_q.raw;
    assign mask_o = r_q.mask;
    assign stat_o = r_q.raw & r_q.mask;
    assign irq_o  = |stat_o;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_o & $past(ev)) == $past(ev)));                  // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_o & $past(wdata & ~ev)) == '0));              // R4
    AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && ev == '0) |=> $stable(raw_o));                     // R2
endmodule

// File: rtl/jsc_state_regs.sv
module jsc_state_regs
    import jsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh,
    input  logic [DW-1:0]    wdata,
    input  logic [NSLOT-1:0] active,
    input  logic [NSLOT-1:0] nxt,
    output logic [DW-1:0]    state_o
);
    logic [DW-1:0]    st_d, st_q;
    logic [NSLOT-1:0] aff;

    always_comb begin
        aff  = wdata[NSLOT-1:0] | wdata[DW-1:NSLOT];
        st_d = st_q;
        for (int n = 0; n < NSLOT; n++) begin
            if (refresh && aff[n]) begin
                st_d[n]         = active[n];
                st_d[NSLOT + n] = nxt[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> $stable(state_o));                                // R6
    AST_STATE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> ((state_o[NSLOT-1:0] & $past(aff)) == ($past(active) & $past(aff)))); // R5
    AST_STATE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> ((state_o[DW-1:NSLOT] & $past(aff)) == ($past(nxt) & $past(aff))));   // R5
endmodule

// File: rtl/jobslot_irq_ctrl.sv
module jobslot_irq_ctrl
    import jsc_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SLOT_BASE = 12'h800,
    parameter int          WIN_BYTES = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_req,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DW-1:0]                 reg_wdata,
    output logic                          rd_valid,
    output logic [DW-1:0]                 rd_data,
    input  logic [NSLOT-1:0]              slot_done,
    input  logic [NSLOT-1:0]              slot_fail,
    input  logic [NSLOT-1:0]              slot_active,
    input  logic [NSLOT-1:0]              slot_next,
    output logic                          irq,
    output logic                          win_req,
    output logic                          win_wr,
    output logic [SLOT_W-1:0]             win_slot,
    output logic [$clog2(WIN_BYTES)-1:0]  win_off,
    output logic [DW-1:0]                 win_wdata,
    input  logic [DW-1:0]                 win_rdata
);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic                is_win;
    loc_sel_e            sel;
    logic [SLOT_W-1:0]   dec_slot;
    logic [OFF_W-1:0]    dec_off;
    logic                loc_wr;
    logic [DW-1:0]       raw, mask, stat, state;
    rd_regs_t            rd_d, rd_q;

    jsc_decode #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .WIN_BYTES(WIN_BYTES)) u_dec (
        .addr(reg_addr), .is_win(is_win), .sel(sel), .slot(dec_slot), .off(dec_off)
    );

    assign loc_wr = reg_req && reg_wr && !is_win;

    jsc_irq_regs u_irq (
        .clk(clk), .rst_n(rst_n),
        .ev({slot_fail, slot_done}),
        .clr_we(loc_wr && sel == SEL_CLR),
        .mask_we(loc_wr && sel == SEL_MASK),
        .wdata(reg_wdata),
        .raw_o(raw), .mask_o(mask), .stat_o(stat), .irq_o(irq)
    );

    jsc_state_regs u_state (
        .clk(clk), .rst_n(rst_n),
        .refresh(loc_wr && sel == SEL_CLR),
        .wdata(reg_wdata), .active(slot_active), .nxt(slot_next),
        .state_o(state)
    );

    assign win_req   = reg_req && is_win;
    assign win_wr    = reg_wr;
    assign win_slot  = dec_slot;
    assign win_off   = dec_off;
    assign win_wdata = reg_wdata;

    always_comb begin
        rd_d.vld  = reg_req && !reg_wr;
        rd_d.data = rd_q.data;
        if (reg_req && !reg_wr) begin
            if (is_win) rd_d.data = win_rdata;
            else begin
                case (sel)
                    SEL_RAW:   rd_d.data = raw;
                    SEL_MASK:  rd_d.data = mask;
                    SEL_STAT:  rd_d.data = stat;
                    SEL_STATE: rd_d.data = state;
                    default:   rd_d.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.vld;
    assign rd_data  = rd_q.data;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr) |=> rd_valid);                            // R8
    AST_WIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        win_req |-> (reg_req && reg_addr >= ADDR_W'(SLOT_BASE)));     // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0));                                 // R3
endmodule

// File: tb/tb_jobslot_irq_ctrl.sv
`timescale 1ns/1ps
module tb_jobslot_irq_ctrl;
    localparam time CYC = 20ns;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_req = 0, reg_wr = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, win_rdata = '0;
    logic [15:0] slot_done = '0, slot_fail = '0, slot_active = '0, slot_next = '0;
    logic        rd_valid, irq, win_req, win_wr;
    logic [31:0] rd_data, win_wdata;
    logic [3:0]  win_slot;
    logic [6:0]  win_off;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] m_raw = '0, m_mask = '0, m_state = '0;

    always #(CYC/2) clk = ~clk;

    jobslot_irq_ctrl dut (.*);

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] local_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_raw;
            12'h008: return m_mask;
            12'h00C: return m_raw & m_mask;
            12'h010: return m_state;
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input logic rq, input logic wr, input logic [11:0] a,
                        input logic [31:0] wd, input logic [15:0] dn, input logic [15:0] fl,
                        input logic [15:0] ac, input logic [15:0] nx, input logic [31:0] wrd);
        logic        win;
        logic        exp_vld;
        logic [31:0] exp_rd, ev;
        logic [15:0] aff;
        @(negedge clk);
        reg_req = rq; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        slot_done = dn; slot_fail = fl; slot_active = ac; slot_next = nx; win_rdata = wrd;
        #1;
        win = (a >= 12'h800);
        check("R7 win_req", {31'b0, win_req}, {31'b0, rq && win});
        if (rq && win) begin
            check("R7 slot", {28'b0, win_slot}, {28'b0, 4'((a - 12'h800) >> 7)});
            check("R7 off",  {25'b0, win_off}, {25'b0, a[6:0]});
            check("R7 wdata", win_wdata, wd);
            check("R7 wr", {31'b0, win_wr}, {31'b0, wr});
        end
        exp_vld = rq && !wr;
        exp_rd  = win ? wrd : local_rd(a);
        ev = {fl, dn};
        if (rq && wr && !win && a == 12'h004) begin
            aff = wd[15:0] | wd[31:16];
            m_raw = (m_raw & ~wd) | ev;
            m_state = (m_state & ~{aff, aff}) | ({nx, ac} & {aff, aff});
        end else begin
            m_raw = m_raw | ev;
            if (rq && wr && !win && a == 12'h008) m_mask = wd;
        end
        @(posedge clk); #1;
        check("R3 irq", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
        check("R8 rd_valid", {31'b0, rd_valid}, {31'b0, exp_vld});
        if (exp_vld) check(win ? "R8 window read" : "R9 local read", rd_data, exp_rd);
    endtask

    task automatic rd(input logic [11:0] a);
        step(1, 0, a, 0, 0, 0, 0, 0, 32'hDEAD_BEEF);
    endtask

    initial begin
        #(CYC * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] la [6];
        la = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014};
        void'($urandom(32'd1234));
        #(CYC * 3); #1;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 rd_valid", {31'b0, rd_valid}, 0);
        rst_n = 1;
        // R1: read back reset values
        rd(12'h000); rd(12'h008); rd(12'h010);
        // R2: done slot 3 and fail slot 5
        step(0, 0, 0, 0, 16'h0008, 16'h0020, 0, 0, 0);
        rd(12'h000);
        // R3: enable mask, irq rises
        step(1, 1, 12'h008, 32'h0020_0000, 0, 0, 0, 0, 0);
        rd(12'h00C);
        // R4: clear and set same bit in one cycle, set wins; clear reads zero
        step(1, 1, 12'h004, 32'h0020_0008, 0, 16'h0020, 16'hA5A5, 16'h0F0F, 0);
        rd(12'h000); rd(12'h004);
        // R5/R6: high-half-only clear refreshes slot 1 only
        step(1, 1, 12'h004, 32'h0002_0000, 0, 0, 16'hFFFF, 16'hFFFF, 0);
        rd(12'h010);
        // R9: writes to read-only offsets ignored
        step(1, 1, 12'h000, 32'h0, 0, 0, 0, 0, 0);
        step(1, 1, 12'h010, 32'hFFFF_FFFF, 0, 0, 16'hFFFF, 16'hFFFF, 0);
        rd(12'h000); rd(12'h010);
        // R7: window edges
        rd(12'h7FC); rd(12'h800); rd(12'hFFF);
        step(1, 1, 12'h8C4, 32'h1234_5678, 0, 0, 0, 0, 0);
        rd(12'h008);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [11:0] a;
            logic [15:0] dn, fl;
            op = $urandom_range(0, 5);
            dn = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            fl = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            a  = la[$urandom_range(0, 5)];
            case (op)
                0: step(0, 0, 0, 0, dn, fl, 16'($urandom), 16'($urandom), $urandom);
                1: step(1, 0, a, 0, dn, fl, 16'($urandom), 16'($urandom), $urandom);
                2: step(1, 1, 12'h008, $urandom, dn, fl, 16'($urandom), 16'($urandom), $urandom);
                3: step(1, 1, 12'h004, $urandom, dn, fl, 16'($urandom), 16'($urandom), $urandom);
                4: step(1, $urandom_range(0, 1), 12'h800 + 12'($urandom_range(0, 2047)),
                        $urandom, dn, fl, 16'($urandom), 16'($urandom), $urandom);
                default: step(1, 1, a, $urandom, dn, fl, 16'($urandom), 16'($urandom), $urandom);
            endcase
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule